// File: doc/BRIEF.md
# Processor Tick Timer Unit

The tick timer is a cycle counter for a small processor core. A 32-bit count advances on each core clock while the timer runs. Its low 28 bits are compared with a programmable 28-bit period. A control register holds the period, a two-bit run mode, an interrupt enable and an interrupt pending flag. The processor reaches the count register, the control register and a read-only presence register through a special-register port. That port has an address, a write strobe, write data and combinational read data.

There are four run modes: stopped, restart-on-match, stop-on-match and free-running. A match sets the pending flag only while the interrupt enable is set. The interrupt line is high while both pending and enable are set. To acknowledge an interrupt, software rewrites the control register with pending written as zero. Writing only the mode field clears pending and disables interrupts, and counting goes on.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 (stopped mode), and irq_o is low.
- R2: A write to the count register (address 0) loads the full 32-bit value. When an increment falls in the same cycle, the written value wins.
- R3: In mode 00 the count holds its value, and no match is signalled even when the count equals the period.
- R4: In mode 11 the count increments every cycle, passes through a match without reloading or stopping, and wraps from 0xFFFFFFFF to 0.
- R5: In mode 01, a match on the current count makes the next count 0. For a start at 0 with period P, the count after n cycles is n mod (P+1).
- R6: In mode 10 the count stops when it reaches the period and then holds.
- R7: The match compares only count[27:0] with the period. Count bits 31:28 do not take part.
- R8: A match sets pending at the following clock edge only when the enable bit is 1. With the enable at 0, pending stays 0.
- R9: A control write with bit 28 at 0 clears pending. A control write with bit 28 at 1 never sets pending. A write of 0xC0000000 clears pending and the enable, and counting continues.
- R10: irq_o is high exactly when pending and enable are both 1.
- R11: Address 2 reads 0x00000001 (timer present). Writes to it are ignored.
- R12: The control register (address 1) reads back with the period in bits 27:0, pending in bit 28, enable in bit 29 and mode in bits 31:30. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sr_addr_i | input | 4 | Register address |
| sr_we_i | input | 1 | Write strobe |
| sr_wdata_i | input | 32 | Write data |
| sr_rdata_o | output | 32 | Read data, combinational on the address |
| irq_o | output | 1 | Timer interrupt |

## Verification
The cases hardest to reach from the ports are the ones that depend on the upper count bits: the 32-bit wrap, and a match while bits 31:28 are nonzero. Counting up to either would take billions of cycles. The stimulus loads the count directly to a value a few cycles short of the event, then checks the count and the flags cycle by cycle. The restart and stop-on-match modes are swept over several small periods, and the count is compared against n mod (P+1) and min(n,P) at every cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    TT_STOP    = 2'b00,
    TT_RESTART = 2'b01,
    TT_SINGLE  = 2'b10,
    TT_FREE    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_count.sv
module tt_count #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  tt_pkg::tt_mode_e     mode_i,
  input  logic [PER_W-1:0]     period_i,
  input  logic                 load_i,
  input  logic [CNT_W-1:0]     load_val_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 match_o
);
  import tt_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign match_o = (mode_i != TT_STOP) && (cnt_q[PER_W-1:0] == period_i);
  assign count_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                                 cnt_d = load_val_i;
    else if (mode_i == TT_RESTART && match_o)   cnt_d = '0;
    else if (mode_i == TT_SINGLE && match_o)    cnt_d = cnt_q;
    else if (mode_i != TT_STOP)                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_load_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_stop_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TT_STOP && !load_i) |=> $stable(cnt_q));
  assert_free_incr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TT_FREE && !load_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_restart_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TT_RESTART && match_o && !load_i) |=> cnt_q == '0);
  assert_single_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TT_SINGLE && match_o && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl #(
  parameter int PER_W = 28
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [PER_W+3:0]     wdata_i,
  input  logic                 match_i,
  output tt_pkg::tt_mode_e     mode_o,
  output logic [PER_W-1:0]     period_o,
  output logic                 ie_o,
  output logic                 pend_o
);
  import tt_pkg::*;

  localparam int PEND_B = PER_W;
  localparam int IE_B   = PER_W + 1;
  localparam int MODE_B = PER_W + 2;

  tt_mode_e         mode_q;
  logic [PER_W-1:0] period_q;
  logic             ie_q, pend_q, pend_d;

  // software may only clear pending; a match with enable set raises it
  always_comb begin
    pend_d = pend_q;
    if (wr_i) pend_d = pend_q & wdata_i[PEND_B];
    if (match_i && ie_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= TT_STOP;
      period_q <= '0;
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_i) begin
        mode_q   <= tt_mode_e'(wdata_i[MODE_B+1:MODE_B]);
        period_q <= wdata_i[PER_W-1:0];
        ie_q     <= wdata_i[IE_B];
      end
    end
  end

  assign mode_o   = mode_q;
  assign period_o = period_q;
  assign ie_o     = ie_q;
  assign pend_o   = pend_q;

  assert_pend_needs_ie_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(ie_q) && $past(match_i));
  assert_no_sw_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !(match_i && ie_q)) |=> !pend_q);
  assert_sw_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[PEND_B] && !(match_i && ie_q)) |=> !pend_q);
endmodule

// File: rtl/tt_rdmux.sv
module tt_rdmux #(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 32,
  parameter int A_COUNT = 0,
  parameter int A_CTRL  = 1,
  parameter int A_PRES  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  ctrl_i,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam logic [CNT_W-1:0] PRESENT_WORD = CNT_W'(1);

  always_comb begin
    unique case (int'(addr_i))
      A_COUNT: rdata_o = count_i;
      A_CTRL:  rdata_o = ctrl_i;
      A_PRES:  rdata_o = PRESENT_WORD;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit #(
  parameter int ADDR_W  = 4,
  parameter int PER_W   = 28,
  parameter int A_COUNT = 0,
  parameter int A_CTRL  = 1,
  parameter int A_PRES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sr_addr_i,
  input  logic              sr_we_i,
  input  logic [PER_W+3:0]  sr_wdata_i,
  output logic [PER_W+3:0]  sr_rdata_o,
  output logic              irq_o
);
  import tt_pkg::*;

  localparam int CNT_W = PER_W + 4;

  tt_mode_e         mode;
  logic [PER_W-1:0] period;
  logic             ie, pend, match;
  logic [CNT_W-1:0] count, ctrl_word;
  logic             wr_cnt, wr_ctrl;

  assign wr_cnt  = sr_we_i && (int'(sr_addr_i) == A_COUNT);
  assign wr_ctrl = sr_we_i && (int'(sr_addr_i) == A_CTRL);

  tt_count #(.CNT_W(CNT_W), .PER_W(PER_W)) u_count (
    .clk_i, .rst_ni,
    .mode_i(mode), .period_i(period),
    .load_i(wr_cnt), .load_val_i(sr_wdata_i),
    .count_o(count), .match_o(match)
  );

  tt_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i(wr_ctrl), .wdata_i(sr_wdata_i), .match_i(match),
    .mode_o(mode), .period_o(period), .ie_o(ie), .pend_o(pend)
  );

  assign ctrl_word = {mode, ie, pend, period};

  tt_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W),
             .A_COUNT(A_COUNT), .A_CTRL(A_CTRL), .A_PRES(A_PRES)) u_rdmux (
    .addr_i(sr_addr_i), .count_i(count), .ctrl_i(ctrl_word), .rdata_o(sr_rdata_o)
  );

  assign irq_o = pend & ie;

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sr_rdata_o[PER_W+1] || int'(sr_addr_i) != A_CTRL));
  assert_match_low_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TT_FREE && !wr_cnt && !wr_ctrl && ie && count[PER_W-1:0] == period) |=> pend);
endmodule

// File: tb/tick_timer_unit_test.sv
module tick_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tick_timer_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .sr_addr_i(addr), .sr_we_i(we),
    .sr_wdata_i(wdata), .sr_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, c0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3); rst_ni = 1'b1; step(1);
    // R1 reset state
    rd(0, v); chk("R1 count", v, 0);
    rd(1, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2/R3 load in stopped mode, count holds
    wr(0, 32'h0000_1234); step(5);
    rd(0, v); chk("R2/R3 hold", v, 32'h0000_1234);
    // R3 stopped with enable and period equal to count: no pending
    wr(1, 32'h2000_1234); step(4);
    rd(1, v); chk("R3 no match", v, 32'h2000_1234);

    // R4 free-running wrap, R2 load wins over increment
    wr(1, 32'hCFFF_FFFF);
    wr(0, 32'hFFFF_FFFD);
    rd(0, v); chk("R2 load wins", v, 32'hFFFF_FFFD);
    step(5); rd(0, v); chk("R4 wrap", v, 32'h0000_0002);

    // R4/R8/R10/R12 free-running through match with enable
    wr(1, 0); wr(0, 32'h0000_000C); wr(1, 32'hF000_0010);
    step(6);
    rd(0, v); chk("R4 no reload", v, 32'h0000_0012);
    rd(1, v); chk("R12 ctrl layout", v, 32'hF000_0010);
    chk("R10 irq high", {31'b0, irq}, 1);
    // R9 writing pending 1 keeps it
    wr(1, 32'hF000_0010);
    rd(1, v); chk("R9 keep pend", v, 32'hF000_0010);
    // R9 acknowledge by writing mode only
    wr(1, 32'hC000_0000);
    rd(1, v); chk("R9 ack ctrl", v, 32'hC000_0000);
    chk("R10 irq low", {31'b0, irq}, 0);
    rd(0, c0); step(3); rd(0, v); chk("R9 counting continues", v, c0 + 3);
    // R9 software cannot set pending
    wr(1, 0); wr(1, 32'h1000_0003);
    rd(1, v); chk("R9 no sw set", v, 32'h0000_0003);

    // R7 match uses low 28 bits only
    wr(1, 0); wr(0, 32'hA000_0005); wr(1, 32'hE000_0008);
    step(3); rd(1, v); chk("R7 before match", v, 32'hE000_0008);
    step(1); rd(1, v); chk("R7 match high bits", v, 32'hF000_0008);
    rd(0, v); chk("R7 count", v, 32'hA000_0009);
    // R8 enable off: match leaves pending clear
    wr(1, 0); wr(0, 32'h0000_0000); wr(1, 32'hC000_0002);
    step(6); rd(1, v); chk("R8 no pend", v, 32'hC000_0002);

    // R5 restart sweep
    for (int p = 1; p <= 4; p++) begin
      wr(1, 0); wr(0, 0); wr(1, 32'h4000_0000 | p);
      for (int n = 0; n <= 2 * p + 3; n++) begin
        rd(0, v); chk("R5 restart count", v, n % (p + 1));
        step(1);
      end
      rd(1, v); chk("R5/R8 pend off", v, 32'h4000_0000 | p);
    end

    // R6 single-run sweep with enable
    for (int p = 2; p <= 5; p++) begin
      wr(1, 0); wr(0, 0); wr(1, 32'hA000_0000 | p);
      for (int n = 0; n <= p + 3; n++) begin
        rd(0, v); chk("R6 single count", v, (n < p) ? n : p);
        chk("R10 single irq", {31'b0, irq}, (n >= p + 1) ? 1 : 0);
        step(1);
      end
    end
    wr(1, 0);

    // R11 presence and R12 unmapped
    rd(2, v); chk("R11 present", v, 1);
    wr(2, 32'h0000_0000); rd(2, v); chk("R11 write ignored", v, 1);
    rd(7, v); chk("R12 unmapped", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule